// File: doc/BRIEF.md
# Tracking Successive-Approximation Divider

This block divides one unsigned 16-bit operand by another and returns the integer quotient. It builds the quotient one bit at a time, starting at the most significant bit. Each cycle it sets the next trial bit and multiplies the trial quotient by the divisor. If the product does not exceed the dividend, the bit is kept. A full conversion therefore takes one clock per quotient bit and needs only a single multiplier and one comparator on its critical path.

For a control loop whose ratio drifts slowly, such as a sensor resistance computed from two converter samples, the block can stay in a tracking mode once a full conversion has finished. In this mode it no longer restarts. It reads the live operands every cycle and moves the held quotient up or down by one LSB towards the new ratio. This gives a fresh estimate on every clock instead of one every sixteen.

A divisor of zero returns a saturated all-ones quotient and raises an error flag. It never starts a conversion.

Top module: `trk_sa_divider`

## Requirements
- R1: For a nonzero divisor, a full conversion returns `quot_o` equal to floor(`num_i` / `den_i`), using the operands sampled on the clock edge where `start_i` was accepted.
- R2: `valid_o` first rises W (16) clock edges after the edge that accepted `start_i`. With `track_i` low it stays high for exactly one cycle.
- R3: When `start_i` is accepted with `den_i` equal to zero, on that same edge `quot_o` becomes all ones, `err_o` becomes 1 and `valid_o` pulses. The next accepted conversion with a nonzero divisor clears `err_o`.
- R4: `start_i` has no effect while a conversion is running. The result and its latency are those of the conversion already under way.
- R5: If `track_i` is high when a conversion completes, the block enters tracking. There `valid_o` is 1 every cycle and, on each edge, `quot_o` moves by at most one LSB towards floor(`num_i`/`den_i`) of the live inputs. It increments when (Q+1)·D ≤ N, decrements when Q·D > N, and otherwise holds.
- R6: In tracking, after a step of k LSB in the ideal quotient, `quot_o` reaches the exact value after k edges. Under a slow ramp (less than one LSB of ratio change per cycle), `quot_o` stays within one LSB of floor(`num_i`/`den_i`).
- R7: Lowering `track_i` while tracking clears `valid_o` on the next edge. After that, `quot_o` holds its value whatever `num_i` and `den_i` do.
- R8: While `rst` is high and after its release, `quot_o` is 0, `valid_o` is 0 and `err_o` is 0.
- R9: In tracking, a live divisor of zero forces `quot_o` to all ones with `err_o` = 1. The first later edge with a nonzero divisor clears `err_o` and resumes stepping from all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a full conversion (ignored while one runs) |
| track_i | input | 1 | Enter or stay in tracking after a conversion |
| num_i | input | W | Dividend, unsigned |
| den_i | input | W | Divisor, unsigned |
| quot_o | output | W | Registered quotient |
| valid_o | output | 1 | Quotient valid: one-cycle pulse, or held high while tracking |
| err_o | output | 1 | Divisor was zero; quotient saturated |

## Verification
Some properties are checked on every cycle. A quotient delivered by a full conversion must bracket the latched dividend, so Q·D ≤ N < (Q+1)·D. A conversion must never stay busy longer than W cycles. A lone `valid_o` pulse must drop on the next cycle. An error must always come with an all-ones quotient. Consecutive tracking outputs must differ by at most one LSB. Other behaviour only the directed scenarios can show: the exact latency count, that a start during a run is ignored, convergence after a step and along slow ramps, how the block leaves tracking, and how it recovers from a zero divisor while tracking.

// File: rtl/trk_div_pkg.sv
package trk_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_TRACK = 2'd2
  } div_state_t;
endpackage

// File: rtl/trk_div_mulcmp.sv
// Multiply a candidate quotient by the divisor and compare with the dividend.
module trk_div_mulcmp #(
  parameter int W = 16
) (
  input  logic [W:0]   cand_i,
  input  logic [W-1:0] den_i,
  input  logic [W-1:0] num_i,
  output logic         fits_o
);
  localparam int PW = 2 * W + 1;
  logic [PW-1:0] prod;

  assign prod   = PW'(cand_i) * PW'(den_i);
  assign fits_o = (prod <= PW'(num_i));
endmodule

// File: rtl/trk_div_bitseq.sv
// One-hot trial-bit pointer walking from MSB to LSB.
module trk_div_bitseq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] mask_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (load_i) begin
      mask_q <= TOP_BIT;
    end else if (step_i) begin
      mask_q <= mask_q >> 1;
    end
  end

  assign mask_o = mask_q;
  assign last_o = mask_q[0];
endmodule

// File: rtl/trk_div_step.sv
// One-LSB tracking update with saturation at both ends.
module trk_div_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] q_i,
  input  logic         up_ok_i,
  input  logic         at_or_below_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] Q_MAX = '1;
  localparam logic [W-1:0] Q_ONE = W'(1);

  always_comb begin
    q_o = q_i;
    if (up_ok_i && (q_i != Q_MAX)) begin
      q_o = q_i + Q_ONE;
    end else if (!at_or_below_i && (q_i != '0)) begin
      q_o = q_i - Q_ONE;
    end
  end
endmodule

// File: rtl/trk_sa_divider.sv
module trk_sa_divider
  import trk_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         track_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quot_o,
  output logic         valid_o,
  output logic         err_o
);
  localparam int CW   = W + 1;
  localparam int NCMP = 2;

  div_state_t   st_q;
  logic [W-1:0] num_q, den_q, qwork_q;
  logic [W-1:0] bit_mask, trial, conv_next, trk_next;
  logic         last_bit, conv_busy, accept, den_zero_in, load_seq;

  logic [CW-1:0] cand    [NCMP];
  logic [W-1:0]  cmp_den [NCMP];
  logic [W-1:0]  cmp_num [NCMP];
  logic          fits    [NCMP];

  assign conv_busy   = (st_q == ST_CONV);
  assign accept      = start_i && !conv_busy;
  assign den_zero_in = (den_i == '0);
  assign load_seq    = accept && !den_zero_in;
  assign trial       = qwork_q | bit_mask;

  // Unit 0: trial bit during a conversion, Q+1 while tracking.
  // Unit 1: Q against the live operands while tracking.
  always_comb begin
    cand[0]    = conv_busy ? {1'b0, trial} : ({1'b0, quot_o} + CW'(1));
    cmp_den[0] = conv_busy ? den_q : den_i;
    cmp_num[0] = conv_busy ? num_q : num_i;
    cand[1]    = {1'b0, quot_o};
    cmp_den[1] = den_i;
    cmp_num[1] = num_i;
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    trk_div_mulcmp #(.W(W)) u_cmp (
      .cand_i (cand[g]),
      .den_i  (cmp_den[g]),
      .num_i  (cmp_num[g]),
      .fits_o (fits[g])
    );
  end

  assign conv_next = fits[0] ? trial : qwork_q;

  trk_div_step #(.W(W)) u_step (
    .q_i           (quot_o),
    .up_ok_i       (fits[0]),
    .at_or_below_i (fits[1]),
    .q_o           (trk_next)
  );

  trk_div_bitseq #(.W(W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_seq),
    .step_i (conv_busy),
    .mask_o (bit_mask),
    .last_o (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      num_q   <= '0;
      den_q   <= '0;
      qwork_q <= '0;
      quot_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      case (st_q)
        ST_CONV: begin
          qwork_q <= conv_next;
          if (last_bit) begin
            quot_o  <= conv_next;
            valid_o <= 1'b1;
            err_o   <= 1'b0;
            st_q    <= track_i ? ST_TRACK : ST_IDLE;
          end
        end
        default: begin
          if (accept) begin
            num_q <= num_i;
            den_q <= den_i;
            if (den_zero_in) begin
              quot_o  <= '1;
              err_o   <= 1'b1;
              valid_o <= 1'b1;
              st_q    <= track_i ? ST_TRACK : ST_IDLE;
            end else begin
              qwork_q <= '0;
              valid_o <= 1'b0;
              st_q    <= ST_CONV;
            end
          end else if (st_q == ST_TRACK) begin
            if (!track_i) begin
              valid_o <= 1'b0;
              st_q    <= ST_IDLE;
            end else begin
              valid_o <= 1'b1;
              if (den_zero_in) begin
                quot_o <= '1;
                err_o  <= 1'b1;
              end else begin
                quot_o <= trk_next;
                err_o  <= 1'b0;
              end
            end
          end else begin
            valid_o <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/trk_div_chk.sv
module trk_div_chk
  import trk_div_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         valid_o,
  input logic         err_o,
  input logic [W-1:0] quot_o,
  input logic [W-1:0] num_q,
  input logic [W-1:0] den_q,
  input div_state_t   st_i
);
  localparam int CNTW = $clog2(W) + 1;
  localparam int PW   = 2 * W + 1;

  logic [CNTW-1:0] busy_cnt;
  logic [W-1:0]    q_prev, q_diff;
  logic            v_prev, e_prev;
  logic [PW-1:0]   lo_p, hi_p, n_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      q_prev   <= '0;
      v_prev   <= 1'b0;
      e_prev   <= 1'b0;
    end else begin
      busy_cnt <= (st_i == ST_CONV) ? busy_cnt + CNTW'(1) : '0;
      q_prev   <= quot_o;
      v_prev   <= valid_o;
      e_prev   <= err_o;
    end
  end

  assign lo_p   = PW'(quot_o) * PW'(den_q);
  assign hi_p   = (PW'(quot_o) + PW'(1)) * PW'(den_q);
  assign n_ext  = PW'(num_q);
  assign q_diff = quot_o - q_prev;

  AST_EXACT_RESULT: assert property (@(posedge clk) disable iff (rst)
    ($rose(valid_o) && !err_o) |-> ((lo_p <= n_ext) && (hi_p > n_ext))); // R1
  AST_CONV_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st_i == ST_CONV) |-> (busy_cnt < CNTW'(W))); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    (valid_o && (st_i == ST_IDLE) && !start_i) |=> !valid_o); // R2
  AST_ZERO_DEN_ONES: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (quot_o == '1)); // R3
  AST_TRACK_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && v_prev && !err_o && !e_prev) |->
      ((q_diff == '0) || (q_diff == W'(1)) || (q_diff == '1))); // R5
endmodule

bind trk_sa_divider trk_div_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .valid_o (valid_o),
  .err_o   (err_o),
  .quot_o  (quot_o),
  .num_q   (num_q),
  .den_q   (den_q),
  .st_i    (st_q)
);

// File: tb/test_trk_sa_divider.sv
module test_trk_sa_divider;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         track_i = 1'b0;
  logic [W-1:0] num_i = '0;
  logic [W-1:0] den_i = '0;
  logic [W-1:0] quot_o;
  logic         valid_o, err_o;

  int n_run = 0;
  int n_fail = 0;

  trk_sa_divider #(.W(W)) i_trk_sa_divider (
    .clk(clk), .rst(rst), .start_i(start_i), .track_i(track_i),
    .num_i(num_i), .den_i(den_i), .quot_o(quot_o), .valid_o(valid_o), .err_o(err_o)
  );

  always #5 clk = ~clk;

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired: act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Issues start and waits for valid; lat counts edges after the accepting edge.
  task automatic do_conv(input int n, input int d, input bit trk, output int lat);
    num_i   = W'(n);
    den_i   = W'(d);
    track_i = trk;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    lat = 0;
    while (!valid_o && lat < 40) begin
      tick();
      lat++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(quot_o == '0 && !valid_o && !err_o, "R8 reset state",
        int'(quot_o) + int'(valid_o) + int'(err_o), 0);
  endtask

  task automatic t_basic();
    int nv [8] = '{1000, 5, 777, 65535, 65535, 12345, 1, 65534};
    int dv [8] = '{7, 9, 777, 1, 65535, 2, 65535, 255};
    int lat;
    for (int i = 0; i < 8; i++) begin
      do_conv(nv[i], dv[i], 1'b0, lat);
      chk(int'(quot_o) == nv[i] / dv[i], "R1 quotient", int'(quot_o), nv[i] / dv[i]);
      if (i == 0) begin
        chk(lat == W, "R2 latency", lat, W);
        tick();
        chk(!valid_o, "R2 single-cycle pulse", int'(valid_o), 0);
      end
    end
  endtask

  task automatic t_zero_den();
    int lat;
    do_conv(4321, 0, 1'b0, lat);
    chk(lat == 0 && valid_o, "R3 zero divisor immediate", lat, 0);
    chk(quot_o == '1 && err_o, "R3 saturated quotient", int'(quot_o), 65535);
    tick();
    chk(!valid_o && err_o, "R3 pulse ends, error kept", int'(valid_o), 0);
    do_conv(900, 30, 1'b0, lat);
    chk(!err_o && quot_o == 16'd30, "R3 error cleared", int'(err_o), 0);
  endtask

  task automatic t_start_ignored();
    int lat;
    num_i   = 16'd60000;
    den_i   = 16'd7;
    track_i = 1'b0;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    lat = 0;
    repeat (3) begin tick(); lat++; end
    num_i   = 16'd10;
    den_i   = 16'd3;
    start_i = 1'b1;
    tick();
    lat++;
    start_i = 1'b0;
    while (!valid_o && lat < 40) begin
      tick();
      lat++;
    end
    chk(int'(quot_o) == 60000 / 7, "R4 start ignored result", int'(quot_o), 60000 / 7);
    chk(lat == W, "R4 start ignored latency", lat, W);
  endtask

  task automatic t_track_step();
    int lat;
    do_conv(50000, 1000, 1'b1, lat);
    chk(quot_o == 16'd50, "R1 tracking seed", int'(quot_o), 50);
    num_i = 16'd55000;
    for (int k = 1; k <= 5; k++) begin
      tick();
      chk(valid_o, "R5 valid held while tracking", int'(valid_o), 1);
      if (k == 1) chk(quot_o == 16'd51, "R5 one LSB per cycle", int'(quot_o), 51);
      if (k == 4) chk(quot_o == 16'd54, "R6 not yet converged", int'(quot_o), 54);
    end
    chk(quot_o == 16'd55, "R6 step up converged", int'(quot_o), 55);
    num_i = 16'd52000;
    repeat (3) tick();
    chk(quot_o == 16'd52, "R6 step down converged", int'(quot_o), 52);
    tick();
    chk(quot_o == 16'd52, "R5 holds when exact", int'(quot_o), 52);
  endtask

  task automatic t_track_exit();
    track_i = 1'b0;
    tick();
    chk(!valid_o, "R7 valid drops on exit", int'(valid_o), 0);
    num_i = 16'd9000;
    den_i = 16'd3;
    repeat (3) tick();
    chk(quot_o == 16'd52 && !valid_o, "R7 quotient held after exit", int'(quot_o), 52);
  endtask

  task automatic t_track_ramp();
    int lat, n, d, e, diff, worst;
    bit ok;
    n = 40000;
    d = 1234;
    do_conv(n, d, 1'b1, lat);
    ok = 1'b1;
    worst = 0;
    for (int i = 0; i < 100; i++) begin
      n += 20;
      num_i = W'(n);
      tick();
      e = n / d;
      diff = int'(quot_o) - e;
      if (diff < 0) diff = -diff;
      if (diff > worst) worst = diff;
      if (diff > 1 || !valid_o) ok = 1'b0;
    end
    chk(ok, "R6 dividend ramp within 1 LSB", worst, 1);
    ok = 1'b1;
    worst = 0;
    for (int i = 0; i < 100; i++) begin
      d -= 1;
      den_i = W'(d);
      tick();
      e = n / d;
      diff = int'(quot_o) - e;
      if (diff < 0) diff = -diff;
      if (diff > worst) worst = diff;
      if (diff > 1 || !valid_o) ok = 1'b0;
    end
    chk(ok, "R6 divisor ramp within 1 LSB", worst, 1);
  endtask

  task automatic t_track_zero();
    int lat;
    do_conv(30000, 300, 1'b1, lat);
    chk(quot_o == 16'd100, "R1 tracking seed 2", int'(quot_o), 100);
    den_i = '0;
    tick();
    chk(quot_o == '1 && err_o && valid_o, "R9 zero divisor in tracking", int'(quot_o), 65535);
    den_i = 16'd300;
    tick();
    chk(!err_o && quot_o == 16'hFFFE, "R9 recovery steps from all ones", int'(quot_o), 65534);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_zero_den();
    t_start_ignored();
    t_track_step();
    t_track_exit();
    t_track_ramp();
    t_track_zero();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule